// File: doc/BRIEF.md
# Banked Register-File Address Decoder

This block turns a register-file access into a physical location inside a data space of four banks. A request carries a 7-bit offset taken from the instruction, two bank-select bits for direct accesses, one bank bit for pointer accesses, an 8-bit pointer register value, a write flag and write data. Offset zero is not a real location. It is the pointer window: an access there uses the pointer-formed address in place of the direct one.

The block classifies the effective 9-bit address into one of four regions: special function register, general-purpose RAM, shared RAM or unimplemented. It holds the 64 bytes of RAM and returns read data for the two RAM regions. For the special-function region it only reports the hit and the effective address; the contents of those registers sit in other blocks. Requests enter on a valid/ready port. Every accepted request, read or write, returns exactly one response on a valid/ready port one cycle later. While a response is waiting and `rsp_ready` is low, `req_ready` drops, so back-pressure passes straight through to the requester.

Top module: `bdm_decoder`

## Requirements
- R1: When `dir_addr` is not 0, the effective address `rsp_addr` is `{bank_sel, dir_addr}`. Bank code 00 is bank 0 and 11 is bank 3.
- R2: When `dir_addr` is 0, the effective address is `{ind_bank, fsr}`. Bit 8 set means bank 2 or 3.
- R3: Offsets 00h to 1Fh in any bank report region code 0 (special function). `rsp_data` is 00h and the RAM is not touched.
- R4: Offsets 40h to 6Fh in bank 0 report region code 1 (general RAM) with `rsp_index` = offset - 40h. The same offsets in banks 1 to 3 are unimplemented.
- R5: Offsets 70h to 7Fh in every bank report region code 2 (shared RAM) with `rsp_index` = 48 + offset - 70h. All four banks reach the same byte.
- R6: All other locations report region code 3 (unimplemented). A read returns 00h and a write changes nothing.
- R7: A pointer access whose pointer lands on the pointer window itself (`fsr[6:0]` = 0) reports region code 3. It reads 00h and a write has no effect.
- R8: A read of a RAM region returns the last byte written to that index. A write response carries `rsp_data` = 00h.
- R9: `req_ready` is high exactly when no response is held or `rsp_ready` is high. An accepted request produces `rsp_valid` on the next cycle. A held response stays stable until it is taken.
- R10: After reset `rsp_valid` is 0, `req_ready` is 1 and every RAM byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| dir_addr | input | 7 | Offset from the instruction |
| bank_sel | input | 2 | Bank for direct accesses |
| ind_bank | input | 1 | Upper address bit for pointer accesses |
| fsr | input | 8 | Pointer register value |
| wr_data | input | 8 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response can be taken |
| rsp_region | output | 2 | 0 special, 1 general RAM, 2 shared RAM, 3 unimplemented |
| rsp_addr | output | 9 | Effective address |
| rsp_index | output | 6 | Physical RAM index (0 outside RAM regions) |
| rsp_data | output | 8 | Read data |

## Verification
The hardest case to reach is the pointer aimed at its own window. It needs a zero offset and a pointer whose low seven bits are zero at once, and random values seldom produce both. The stimulus therefore biases about a third of the offsets to zero and a quarter of the pointers to window values in each bank. Directed steps then write through that self-reference and read the touched bytes back. A second hard case is a response held under back-pressure while a new request waits. A directed step holds `rsp_ready` low for a cycle and checks the held data against the waiting request.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  typedef enum logic [1:0] {
    RGN_SFR  = 2'd0,
    RGN_GPR  = 2'd1,
    RGN_COM  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/bdm_addr_former.sv
module bdm_addr_former #(
  parameter int OFF_W  = 7,
  parameter int BANK_W = 2,
  parameter int PTR_W  = 8,
  localparam int EFF_W = OFF_W + BANK_W
) (
  input  logic [OFF_W-1:0]  dir_addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              ind_bank,
  input  logic [PTR_W-1:0]  fsr,
  output logic [EFF_W-1:0]  eff_addr,
  output logic              self_ref
);
  logic use_ptr;

  // offset zero is the pointer window
  assign use_ptr  = (dir_addr == '0);
  assign eff_addr = use_ptr ? EFF_W'({ind_bank, fsr}) : {bank_sel, dir_addr};
  assign self_ref = use_ptr && (fsr[OFF_W-1:0] == '0);
endmodule

// File: rtl/bdm_region_map.sv
module bdm_region_map
  import bdm_pkg::*;
#(
  parameter int OFF_W    = 7,
  parameter int BANK_W   = 2,
  parameter int SFR_END  = 'h1F,
  parameter int GPR_BASE = 'h40,
  parameter int GPR_END  = 'h6F,
  parameter int COM_BASE = 'h70,
  parameter int IDX_W    = 6,
  localparam int EFF_W   = OFF_W + BANK_W
) (
  input  logic [EFF_W-1:0] addr,
  input  logic             self_ref,
  output region_e          region,
  output logic [IDX_W-1:0] idx
);
  localparam logic [OFF_W-1:0] L_SFR_END  = OFF_W'(SFR_END);
  localparam logic [OFF_W-1:0] L_GPR_BASE = OFF_W'(GPR_BASE);
  localparam logic [OFF_W-1:0] L_GPR_END  = OFF_W'(GPR_END);
  localparam logic [OFF_W-1:0] L_COM_BASE = OFF_W'(COM_BASE);
  localparam logic [IDX_W-1:0] L_GPR_CNT  = IDX_W'(GPR_END - GPR_BASE + 1);

  logic [OFF_W-1:0]  off;
  logic [BANK_W-1:0] bank;
  logic [OFF_W-1:0]  gpr_rel;
  logic [OFF_W-1:0]  com_rel;

  assign off     = addr[OFF_W-1:0];
  assign bank    = addr[EFF_W-1:OFF_W];
  assign gpr_rel = off - L_GPR_BASE;
  assign com_rel = off - L_COM_BASE;

  always_comb begin
    region = RGN_NONE;
    idx    = '0;
    if (self_ref) begin
      region = RGN_NONE;
    end else if (off <= L_SFR_END) begin
      region = RGN_SFR;
    end else if (off >= L_COM_BASE) begin
      region = RGN_COM;
      idx    = L_GPR_CNT + IDX_W'(com_rel);
    end else if ((bank == '0) && (off >= L_GPR_BASE) && (off <= L_GPR_END)) begin
      region = RGN_GPR;
      idx    = IDX_W'(gpr_rel);
    end
  end
endmodule

// File: rtl/bdm_ram.sv
module bdm_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                q <= '0;
      else if (we && (waddr == IDX_W'(i)))       q <= wdata;
    end
    assign words[i] = q;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/bdm_decoder.sv
module bdm_decoder
  import bdm_pkg::*;
#(
  parameter int OFF_W    = 7,
  parameter int BANK_W   = 2,
  parameter int PTR_W    = 8,
  parameter int DATA_W   = 8,
  parameter int SFR_END  = 'h1F,
  parameter int GPR_BASE = 'h40,
  parameter int GPR_END  = 'h6F,
  parameter int COM_BASE = 'h70,
  localparam int EFF_W   = OFF_W + BANK_W,
  localparam int DEPTH   = (GPR_END - GPR_BASE + 1) + ((1 << OFF_W) - COM_BASE),
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  dir_addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              ind_bank,
  input  logic [PTR_W-1:0]  fsr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_region,
  output logic [EFF_W-1:0]  rsp_addr,
  output logic [IDX_W-1:0]  rsp_index,
  output logic [DATA_W-1:0] rsp_data
);
  logic [EFF_W-1:0]  eff_addr;
  logic              self_ref;
  region_e           region;
  logic [IDX_W-1:0]  idx;
  logic              is_ram;
  logic              accept;
  logic              ram_we;
  logic [DATA_W-1:0] ram_q;

  bdm_addr_former #(.OFF_W(OFF_W), .BANK_W(BANK_W), .PTR_W(PTR_W)) u_form (
    .dir_addr(dir_addr), .bank_sel(bank_sel), .ind_bank(ind_bank), .fsr(fsr),
    .eff_addr(eff_addr), .self_ref(self_ref)
  );

  bdm_region_map #(
    .OFF_W(OFF_W), .BANK_W(BANK_W), .SFR_END(SFR_END), .GPR_BASE(GPR_BASE),
    .GPR_END(GPR_END), .COM_BASE(COM_BASE), .IDX_W(IDX_W)
  ) u_map (
    .addr(eff_addr), .self_ref(self_ref), .region(region), .idx(idx)
  );

  bdm_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(idx), .wdata(wr_data),
    .raddr(idx), .rdata(ram_q)
  );

  assign is_ram    = (region == RGN_GPR) || (region == RGN_COM);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign ram_we    = accept && req_write && is_ram;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_region <= RGN_NONE;
      rsp_addr   <= '0;
      rsp_index  <= '0;
      rsp_data   <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_region <= region;
      rsp_addr   <= eff_addr;
      rsp_index  <= idx;
      rsp_data   <= (!req_write && is_ram) ? ram_q : '0;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/bdm_decoder_chk.sv
module bdm_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [6:0] dir_addr,
  input logic [1:0] bank_sel,
  input logic       ind_bank,
  input logic [7:0] fsr,
  input logic [7:0] wr_data,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [1:0] rsp_region,
  input logic [8:0] rsp_addr,
  input logic [5:0] rsp_index,
  input logic [7:0] rsp_data
);
  // R9
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  // R9
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_addr) && $stable(rsp_region));
  // R9
  stall_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  // R3
  sfr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_region == 2'd0 |-> rsp_addr[6:0] <= 7'h1F && rsp_data == 8'h00);
  // R4
  gpr_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_region == 2'd1 |-> rsp_addr[8:7] == 2'b00 && rsp_index < 6'd48);
  // R5
  com_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_region == 2'd2 |-> rsp_index == 6'd48 + {2'b00, rsp_addr[3:0]});
  // R6
  none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_region == 2'd3 |-> rsp_data == 8'h00);
endmodule

bind bdm_decoder bdm_decoder_chk u_chk (.*);

// File: tb/sim_bdm_decoder.sv
module sim_bdm_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [6:0] dir_addr = '0;
  logic [1:0] bank_sel = '0;
  logic       ind_bank = 1'b0;
  logic [7:0] fsr = '0;
  logic [7:0] wr_data = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [1:0] rsp_region;
  logic [8:0] rsp_addr;
  logic [5:0] rsp_index;
  logic [7:0] rsp_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [64];

  always #10 clk = ~clk;

  bdm_decoder u0 (.*);

  function automatic logic [8:0] f_eff(logic [6:0] d, logic [1:0] b, logic ib, logic [7:0] p);
    return (d == 7'd0) ? {ib, p} : {b, d};
  endfunction

  function automatic logic [1:0] f_region(logic [8:0] a, logic selfp);
    if (selfp) return 2'd3;
    if (a[6:0] <= 7'h1F) return 2'd0;
    if (a[6:0] >= 7'h70) return 2'd2;
    if (a[8:7] == 2'b00 && a[6:0] >= 7'h40) return 2'd1;
    return 2'd3;
  endfunction

  function automatic logic [5:0] f_index(logic [8:0] a, logic [1:0] r);
    if (r == 2'd1) return 6'(a[6:0] - 7'h40);
    if (r == 2'd2) return 6'd48 + {2'b00, a[3:0]};
    return 6'd0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request with rsp_ready high; inputs set at negedge, results sampled at next negedge
  task automatic access(logic wr, logic [6:0] d, logic [1:0] b, logic ib, logic [7:0] p, logic [7:0] v);
    logic [8:0] a;
    logic [1:0] r;
    logic [5:0] ix;
    logic [7:0] ed;
    logic       sp;
    a  = f_eff(d, b, ib, p);
    sp = (d == 7'd0) && (p[6:0] == 7'd0);
    r  = f_region(a, sp);
    ix = f_index(a, r);
    ed = (!wr && (r == 2'd1 || r == 2'd2)) ? model[ix] : 8'h00;
    if (wr && (r == 2'd1 || r == 2'd2)) model[ix] = v;
    req_write = wr; dir_addr = d; bank_sel = b; ind_bank = ib; fsr = p; wr_data = v;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 rsp_valid", int'(rsp_valid), 1);
    check((d == 0) ? "R2 addr" : "R1 addr", int'(rsp_addr), int'(a));
    check(sp ? "R7 region" : (r == 0 ? "R3 region" : (r == 1 ? "R4 region" : (r == 2 ? "R5 region" : "R6 region"))),
          int'(rsp_region), int'(r));
    check("R4 R5 index", int'(rsp_index), int'(ix));
    check("R8 data", int'(rsp_data), int'(ed));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10
    check("R10 rsp_valid", int'(rsp_valid), 0);
    check("R10 req_ready", int'(req_ready), 1);
    access(1'b0, 7'h45, 2'd0, 1'b0, 8'h00, 8'h00);
    access(1'b0, 7'h7F, 2'd3, 1'b0, 8'h00, 8'h00);

    // R4 R8 direct GPR write/read, bank 1 mirror not implemented (R6)
    access(1'b1, 7'h40, 2'd0, 1'b0, 8'h00, 8'hA5);
    access(1'b1, 7'h6F, 2'd0, 1'b0, 8'h00, 8'h3C);
    access(1'b1, 7'h45, 2'd1, 1'b0, 8'h00, 8'h99);
    access(1'b0, 7'h45, 2'd1, 1'b0, 8'h00, 8'h00);
    access(1'b0, 7'h40, 2'd0, 1'b0, 8'h00, 8'h00);
    access(1'b0, 7'h6F, 2'd0, 1'b0, 8'h00, 8'h00);
    // R5 shared RAM alias across banks
    access(1'b1, 7'h72, 2'd2, 1'b0, 8'h00, 8'h5A);
    access(1'b0, 7'h72, 2'd0, 1'b0, 8'h00, 8'h00);
    access(1'b0, 7'h00, 2'd0, 1'b1, 8'hF2, 8'h00);
    // R3 SFR in each bank
    access(1'b1, 7'h1F, 2'd3, 1'b0, 8'h00, 8'h77);
    access(1'b0, 7'h01, 2'd2, 1'b0, 8'h00, 8'h00);
    // R6 unimplemented 20h-3Fh
    access(1'b1, 7'h20, 2'd0, 1'b0, 8'h00, 8'h11);
    access(1'b0, 7'h3F, 2'd0, 1'b0, 8'h00, 8'h00);
    // R2 pointer into GPR
    access(1'b1, 7'h00, 2'd3, 1'b0, 8'h50, 8'hC3);
    access(1'b0, 7'h50, 2'd0, 1'b0, 8'h00, 8'h00);
    // R7 self-reference in each pointer bank
    access(1'b1, 7'h00, 2'd0, 1'b0, 8'h00, 8'hEE);
    access(1'b1, 7'h00, 2'd0, 1'b1, 8'h80, 8'hEE);
    access(1'b0, 7'h00, 2'd1, 1'b0, 8'h80, 8'h00);
    access(1'b0, 7'h40, 2'd0, 1'b0, 8'h00, 8'h00);

    // R9 back-pressure: hold one response while the next request waits
    rsp_ready = 1'b0;
    access(1'b0, 7'h40, 2'd0, 1'b0, 8'h00, 8'h00);
    check("R9 req_ready low", int'(req_ready), 0);
    req_write = 1'b0; dir_addr = 7'h72; bank_sel = 2'd1; req_valid = 1'b1;
    @(negedge clk);
    check("R9 held valid", int'(rsp_valid), 1);
    check("R9 held data", int'(rsp_data), int'(model[0]));
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next data", int'(rsp_data), int'(model[50]));
    check("R9 next addr", int'(rsp_addr), 9'h0F2);
    @(negedge clk);
    check("R9 drain", int'(rsp_valid), 0);

    // random mix, biased toward the pointer window and its self-reference
    for (int n = 0; n < 800; n++) begin
      logic [6:0] d;
      logic [7:0] p;
      d = ($urandom % 3 == 0) ? 7'h00 : 7'($urandom);
      p = ($urandom % 4 == 0) ? {1'($urandom), 7'h00} : 8'($urandom);
      access(1'($urandom), d, 2'($urandom), 1'($urandom), p, 8'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule